// File: doc/BRIEF.md
# Switch Companion-Model History Updater

This block keeps the history current source of one circuit element of a fixed-step, backward-Euler network solver. On every timestep strobe it takes the voltage across the element, which is the difference of its two terminal node voltages. It then forms the new history current as one coefficient times that voltage plus a second coefficient times the previous history current. The result is stored and presented until the next step. Many copies run side by side, one per element, all stepped by the same strobe.

For power-electronic switches the element is a fixed conductance in parallel with a current source. The conductance never depends on the switch state, so the network matrix stays constant. The switch state only selects which of two coefficient pairs, ON or OFF, drives the update. The state comes either from an external gate bit (a controllable switch) or from the element's own voltage and current (a diode-type switch). Gate and voltages are sampled once, at the edge that accepts the strobe. An edge arriving later in the step takes effect on the next step.

The controller is a four-state machine. WAIT idles until a strobe is accepted (transition *accept*) and captures the inputs. DECIDE settles the switch state (transition *decided*). MULT registers both products (transition *multiplied*). ACCUM sums, scales, saturates, writes the history register and pulses the done flag (transition *written*, back to WAIT). Reset forces WAIT from any state.

Top module: `swh_hist_update`

## Requirements
- R1: Reset (rst_n low) clears the history output to 0, forces the switch OFF (sw_on_o = 0) and holds done_o low.
- R2: A high step_i is accepted only in WAIT. hist_o and done_o update on the third rising edge after the accepting edge, and done_o is high for exactly that one cycle. A strobe seen while busy is ignored and produces no further done pulse and no change of hist_o.
- R3: The element voltage (vnode_p_i − vnode_n_i, computed one bit wider than DW), gate_i and mode_i are captured at the accepting edge. Changes to them later in the same step have no effect on that step's result.
- R4: The new history value is floor((γ·v + κ·h_prev) / 2^FRAC). γ and κ are signed CW-bit fixed-point values with FRAC fraction bits, v is the captured voltage, and h_prev is the history value before the update.
- R5: A result above 2^(DW−1)−1 or below −2^(DW−1) is clamped to that bound.
- R6: The pair (gam_on_i, kap_on_i) is used when the switch state decided in this step is ON, and (gam_off_i, kap_off_i) when it is OFF.
- R7: mode_i encoding: 0 = linear element, 1 = gated switch, 2 = diode-type switch, 3 = treated as linear. In linear mode the switch state is always OFF.
- R8: In gated mode the switch state becomes the captured gate bit.
- R9: In diode mode an OFF switch turns ON when the captured voltage is strictly above zero. An ON switch turns OFF when the history value before the update is negative. Otherwise the state holds.
- R10: Between steps hist_o and sw_on_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Timestep strobe |
| mode_i | input | 2 | Element kind (0 linear, 1 gated, 2 diode, 3 linear) |
| gate_i | input | 1 | External gate bit for a gated switch |
| vnode_p_i | input | DW | Signed voltage of the positive terminal node |
| vnode_n_i | input | DW | Signed voltage of the negative terminal node |
| gam_on_i | input | CW | Voltage coefficient, ON state |
| kap_on_i | input | CW | History coefficient, ON state |
| gam_off_i | input | CW | Voltage coefficient, OFF state |
| kap_off_i | input | CW | History coefficient, OFF state |
| hist_o | output | DW | Signed history current |
| sw_on_o | output | 1 | Present switch state (1 = ON) |
| done_o | output | 1 | One-cycle pulse when hist_o is updated |

## Verification
The bench builds the block with DW = 16, CW = 16 and FRAC = 12, so the coefficients span about ±8 with a resolution of 1/4096. Full-scale node voltages of opposite sign push the 17-bit voltage difference times a near-maximum coefficient past both clamp bounds. Tiny negative products exercise the floor rounding at the scaling step. Directed steps walk the diode through its OFF→ON and ON→OFF transitions. Random steps mix all four mode codes with changing gates and coefficients.

// File: rtl/swh_pkg.sv
package swh_pkg;

    typedef enum logic [1:0] {
        ST_WAIT   = 2'd0,
        ST_DECIDE = 2'd1,
        ST_MULT   = 2'd2,
        ST_ACCUM  = 2'd3
    } swh_state_t;

    typedef enum logic [1:0] {
        MD_LINEAR = 2'd0,
        MD_GATED  = 2'd1,
        MD_DIODE  = 2'd2,
        MD_SPARE  = 2'd3
    } swh_mode_t;

endpackage

// File: rtl/swh_state_sel.sv
module swh_state_sel
    import swh_pkg::*;
#(
    parameter int DW = 16,
    parameter int VW = DW + 1
) (
    input  swh_mode_t             mode,
    input  logic                  cur_on,
    input  logic                  gate_s,
    input  logic signed [VW-1:0]  volt_s,
    input  logic signed [DW-1:0]  hist_prev,
    output logic                  next_on
);

    always_comb begin
        unique case (mode)
            MD_GATED: next_on = gate_s;
            MD_DIODE: begin
                if (!cur_on)
                    next_on = (volt_s > 0);
                else
                    next_on = !(hist_prev < 0);
            end
            default:  next_on = 1'b0;
        endcase
    end

endmodule

// File: rtl/swh_mac.sv
module swh_mac #(
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int FRAC = 12,
    parameter int VW   = DW + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ld_prod,
    input  logic signed [CW-1:0]  gam,
    input  logic signed [CW-1:0]  kap,
    input  logic signed [VW-1:0]  volt,
    input  logic signed [DW-1:0]  hist_prev,
    output logic signed [DW-1:0]  hist_new
);

    localparam int PW   = CW + VW;
    localparam int ACCW = PW + 1;
    localparam logic signed [ACCW-1:0] HMAX =
        {{(ACCW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [ACCW-1:0] HMIN =
        {{(ACCW-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [PW-1:0]   prod_g_q;
    logic signed [PW-1:0]   prod_k_q;
    logic signed [ACCW-1:0] acc;
    logic signed [ACCW-1:0] scaled;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_g_q <= '0;
            prod_k_q <= '0;
        end else if (ld_prod) begin
            prod_g_q <= PW'(gam) * PW'(volt);
            prod_k_q <= PW'(kap) * PW'(hist_prev);
        end
    end

    always_comb acc = ACCW'(prod_g_q) + ACCW'(prod_k_q);

    generate
        if (FRAC == 0) begin : g_noscale
            always_comb scaled = acc;
        end else begin : g_scale
            always_comb scaled = acc >>> FRAC;
        end
    endgenerate

    always_comb begin
        if (scaled > HMAX)
            hist_new = HMAX[DW-1:0];
        else if (scaled < HMIN)
            hist_new = HMIN[DW-1:0];
        else
            hist_new = scaled[DW-1:0];
    end

endmodule

// File: rtl/swh_hist_update.sv
module swh_hist_update
    import swh_pkg::*;
#(
    parameter int DW   = 16,
    parameter int CW   = 16,
    parameter int FRAC = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  step_i,
    input  logic [1:0]            mode_i,
    input  logic                  gate_i,
    input  logic signed [DW-1:0]  vnode_p_i,
    input  logic signed [DW-1:0]  vnode_n_i,
    input  logic signed [CW-1:0]  gam_on_i,
    input  logic signed [CW-1:0]  kap_on_i,
    input  logic signed [CW-1:0]  gam_off_i,
    input  logic signed [CW-1:0]  kap_off_i,
    output logic signed [DW-1:0]  hist_o,
    output logic                  sw_on_o,
    output logic                  done_o
);

    localparam int VW = DW + 1;

    swh_state_t            state_q, state_d;
    swh_mode_t             mode_q;
    logic signed [VW-1:0]  volt_q;
    logic                  gate_q;
    logic                  sw_q;
    logic signed [DW-1:0]  hist_q;
    logic                  done_q;

    logic                  accept;
    logic                  ld_sw;
    logic                  ld_prod;
    logic                  ld_acc;
    logic                  sw_next;
    logic signed [DW-1:0]  hist_new;
    logic signed [CW-1:0]  gam_sel;
    logic signed [CW-1:0]  kap_sel;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // transitions: accept, decided, multiplied, written
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:   if (step_i) state_d = ST_DECIDE;
            ST_DECIDE: state_d = ST_MULT;
            ST_MULT:   state_d = ST_ACCUM;
            ST_ACCUM:  state_d = ST_WAIT;
            default:   state_d = ST_WAIT;
        endcase
    end

    // state-decoded controls
    always_comb begin
        accept  = 1'b0;
        ld_sw   = 1'b0;
        ld_prod = 1'b0;
        ld_acc  = 1'b0;
        unique case (state_q)
            ST_WAIT:   accept  = step_i;
            ST_DECIDE: ld_sw   = 1'b1;
            ST_MULT:   ld_prod = 1'b1;
            ST_ACCUM:  ld_acc  = 1'b1;
            default:   ;
        endcase
    end

    // captured step inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            volt_q <= '0;
            gate_q <= 1'b0;
            mode_q <= MD_LINEAR;
        end else if (accept) begin
            volt_q <= {vnode_p_i[DW-1], vnode_p_i} - {vnode_n_i[DW-1], vnode_n_i};
            gate_q <= gate_i;
            mode_q <= swh_mode_t'(mode_i);
        end
    end

    // switch state and history register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_q   <= 1'b0;
            hist_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= ld_acc;
            if (ld_sw)  sw_q   <= sw_next;
            if (ld_acc) hist_q <= hist_new;
        end
    end

    swh_state_sel #(.DW(DW), .VW(VW)) u_sel (
        .mode      (mode_q),
        .cur_on    (sw_q),
        .gate_s    (gate_q),
        .volt_s    (volt_q),
        .hist_prev (hist_q),
        .next_on   (sw_next)
    );

    always_comb begin
        gam_sel = sw_q ? gam_on_i : gam_off_i;
        kap_sel = sw_q ? kap_on_i : kap_off_i;
    end

    swh_mac #(.DW(DW), .CW(CW), .FRAC(FRAC), .VW(VW)) u_mac (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_prod   (ld_prod),
        .gam       (gam_sel),
        .kap       (kap_sel),
        .volt      (volt_q),
        .hist_prev (hist_q),
        .hist_new  (hist_new)
    );

    assign hist_o  = hist_q;
    assign sw_on_o = sw_q;
    assign done_o  = done_q;

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (hist_o == '0 && !sw_on_o && !done_o && state_q == ST_WAIT));

    // R2
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    a_r2_accept_only_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_WAIT) |=> (state_q != ST_DECIDE));

    // R7
    a_r7_linear_off: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECIDE && (mode_q == MD_LINEAR || mode_q == MD_SPARE)) |=> !sw_on_o);

    // R8
    a_r8_gate_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECIDE && mode_q == MD_GATED) |=> (sw_on_o == $past(gate_q)));

    // R9
    a_r9_diode_turn_on: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECIDE && mode_q == MD_DIODE && !sw_on_o && volt_q > 0) |=> sw_on_o);

    // R10
    a_r10_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_ACCUM) |=> $stable(hist_o));

    // R10
    a_r10_sw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_DECIDE) |=> $stable(sw_on_o));

endmodule

// File: tb/sim_swh_hist_update.sv
module sim_swh_hist_update;

    localparam int DW   = 16;
    localparam int CW   = 16;
    localparam int FRAC = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_i = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic gate_i = 1'b0;
    logic signed [DW-1:0] vnode_p_i = '0, vnode_n_i = '0;
    logic signed [CW-1:0] gam_on_i = '0, kap_on_i = '0, gam_off_i = '0, kap_off_i = '0;
    logic signed [DW-1:0] hist_o;
    logic sw_on_o, done_o;

    int checks = 0;
    int errors = 0;
    int m_h = 0;
    bit m_sw = 1'b0;

    always #5 clk = ~clk;

    swh_hist_update #(.DW(DW), .CW(CW), .FRAC(FRAC)) u0 (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .mode_i(mode_i), .gate_i(gate_i),
        .vnode_p_i(vnode_p_i), .vnode_n_i(vnode_n_i),
        .gam_on_i(gam_on_i), .kap_on_i(kap_on_i), .gam_off_i(gam_off_i), .kap_off_i(kap_off_i),
        .hist_o(hist_o), .sw_on_o(sw_on_o), .done_o(done_o)
    );

    function automatic int ref_h(input int g, input int k, input int v, input int h);
        longint acc, hmax, hmin;
        hmax = (longint'(1) <<< (DW-1)) - 1;
        hmin = -(longint'(1) <<< (DW-1));
        acc = longint'(g) * longint'(v) + longint'(k) * longint'(h);
        acc = acc >>> FRAC;
        if (acc > hmax) acc = hmax;
        if (acc < hmin) acc = hmin;
        return int'(acc);
    endfunction

    function automatic bit ref_sw(input int md, input bit cur, input bit g, input int v, input int hp);
        if (md == 1) return g;
        if (md == 2) return cur ? !(hp < 0) : (v > 0);
        return 1'b0;
    endfunction

    task automatic check(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic do_step(input int md, input int vp, input int vn, input bit g,
                           input int go, input int ko, input int gf, input int kf,
                           input bit poke_mid, input bit poke_busy, input string req);
        int v, lat, exp_h, hold_h;
        bit exp_sw, extra;
        v = vp - vn;
        exp_sw = ref_sw(md, m_sw, g, v, m_h);
        exp_h = exp_sw ? ref_h(go, ko, v, m_h) : ref_h(gf, kf, v, m_h);
        @(negedge clk);
        mode_i = md[1:0]; gate_i = g;
        vnode_p_i = DW'(vp); vnode_n_i = DW'(vn);
        gam_on_i = CW'(go); kap_on_i = CW'(ko); gam_off_i = CW'(gf); kap_off_i = CW'(kf);
        step_i = 1'b1;
        lat = 0;
        for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            if (i == 1) begin
                step_i = 1'b0;
                if (poke_mid) begin
                    gate_i = ~g; vnode_p_i = ~vnode_p_i; mode_i = ~mode_i;
                end
            end
            if (poke_busy && i == 2) step_i = 1'b1;
            if (poke_busy && i == 3) step_i = 1'b0;
            if (done_o) begin lat = i; break; end
        end
        check("R2", "latency", lat, 4);
        check(req, "hist", int'(hist_o), exp_h);
        check(req, "switch", int'(sw_on_o), int'(exp_sw));
        m_h = exp_h; m_sw = exp_sw;
        if (poke_busy) begin
            extra = 1'b0;
            hold_h = int'(hist_o);
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (done_o) extra = 1'b1;
            end
            check("R2", "busy strobe gave done", int'(extra), 0);
            check("R10", "hist held after busy strobe", int'(hist_o), hold_h);
        end
    endtask

    task automatic do_reset(input string req);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        m_h = 0; m_sw = 1'b0;
        check(req, "reset hist", int'(hist_o), 0);
        check(req, "reset switch", int'(sw_on_o), 0);
        check(req, "reset done", int'(done_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int hold;
        void'($urandom(32'd7331));
        do_reset("R1");

        // R7 linear, R4 accumulation with half-weight history
        do_step(0, 1000, 200, 1'b1, 100, 100, 4096, 2048, 1'b0, 1'b0, "R7");
        do_step(0, 1000, 200, 1'b1, 100, 100, 4096, 2048, 1'b0, 1'b0, "R4");
        // R7 spare code behaves as linear
        do_step(3, -300, 100, 1'b1, 100, 100, 4096, 0, 1'b0, 1'b0, "R7");
        // R4 floor on tiny negative product
        do_step(0, -1, 0, 1'b0, 0, 0, 1, 0, 1'b0, 1'b0, "R4");
        // R8 / R6 gated on and off pairs
        do_step(1, 500, 0, 1'b1, 8192, 4096, 1, 1, 1'b0, 1'b0, "R8");
        do_step(1, 500, 0, 1'b0, 8192, 4096, 4096, 0, 1'b0, 1'b0, "R6");
        // R3 inputs changed after capture
        do_step(1, 700, 100, 1'b1, 4096, 1024, 2048, 0, 1'b1, 1'b0, "R3");
        // R2 strobe while busy
        do_step(1, 200, 50, 1'b0, 4096, 0, 4096, 4096, 1'b0, 1'b1, "R2");
        // R10 idle hold
        hold = int'(hist_o);
        repeat (5) @(negedge clk);
        check("R10", "idle hist", int'(hist_o), hold);
        check("R10", "idle switch", int'(sw_on_o), int'(m_sw));
        // R9 diode walk
        do_reset("R1");
        do_step(2, -5, 0, 1'b1, 4096, 0, 4096, 0, 1'b0, 1'b0, "R9");
        do_step(2, 0, 0, 1'b1, 4096, 0, 4096, 0, 1'b0, 1'b0, "R9");
        do_step(2, 5, 0, 1'b0, -4096, 0, 4096, 0, 1'b0, 1'b0, "R9");
        do_step(2, -50, 0, 1'b0, 4096, 4096, 4096, 0, 1'b0, 1'b0, "R9");
        do_step(2, -50, 0, 1'b0, 4096, 4096, 4096, 0, 1'b0, 1'b0, "R9");
        do_step(2, 30, 0, 1'b0, 4096, 0, 4096, 0, 1'b0, 1'b0, "R9");
        // R5 clamping both ways
        do_step(0, 32767, -32768, 1'b0, 0, 0, 32767, 0, 1'b0, 1'b0, "R5");
        do_step(0, -32768, 32767, 1'b0, 0, 0, 32767, 0, 1'b0, 1'b0, "R5");
        do_step(0, 100, 0, 1'b0, 0, 0, 0, -32768, 1'b0, 1'b0, "R5");
        // R1 reset mid-run
        do_reset("R1");
        // random mix
        for (int n = 0; n < 80; n++) begin
            do_step(int'($urandom_range(3, 0)),
                    int'($signed(16'($urandom))), int'($signed(16'($urandom))),
                    1'($urandom),
                    int'($urandom_range(16383, 0)) - 8192, int'($urandom_range(8191, 0)) - 4096,
                    int'($urandom_range(16383, 0)) - 8192, int'($urandom_range(8191, 0)) - 4096,
                    1'b0, 1'b0, "R4");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule